// File: doc/BRIEF.md
# Aggregation Feature and Pair-Result Cache

This block sits inside a graph-learning processing element and answers neighbour-aggregation requests. A request names one node, which returns that node's feature vector, or two nodes, which returns the lane-wise sum of both vectors. Two small fully associative stores back these answers. The feature store keeps single-node vectors tagged by node ID. The pair store keeps two-node partial sums tagged by the node pair. Feature misses go out over a memory request/response port, and the returned vector is written into the feature store.

With the reuse input high, a pair request first probes the pair store. A hit returns the stored sum at once, and neither node is looked up. On a miss the block falls back to one feature lookup per node and fetches each missing node from memory. If the request carries a keep hint, the block then writes the new sum into the pair store. Both stores evict their least-recently-used entry.

The request, response and memory interfaces are valid/ready streams, and only one request is in flight at a time. `req_ready` is high only while the block is idle. A response holds `rsp_valid`, `rsp_data` and `rsp_pair_hit` unchanged until `rsp_ready` is sampled high. `mem_req_valid` and `mem_req_node` hold until `mem_req_ready` is seen. `mem_rsp_ready` is high only while a fetch is awaiting its data.

Top module: `agg_reuse_cache`

## Requirements
- R1: A single-node request whose node is in the feature store produces `rsp_valid` in the cycle right after acceptance, with that node's vector and no memory request.
- R2: A feature-store miss issues exactly one memory request carrying the node ID on `mem_req_node`. The response comes after the memory data, and the returned vector is written into the feature store, so a repeat request hits.
- R3: A pair request returns, in each of LANES lanes of ELEM_W bits (lane k in bits k*ELEM_W and up), the sum of the two nodes' lanes modulo 2^ELEM_W.
- R4: With `reuse_en` high, a pair request is first looked up in the pair store. On a hit the stored sum is returned one cycle after acceptance with `rsp_pair_hit`=1, and no memory request is made.
- R5: On a pair miss each node is looked up individually, and missing nodes are fetched, first node before second. A pair naming the same node twice fetches it once and returns twice its vector.
- R6: The pair tag holds the smaller ID first, so requests (a,b) and (b,a) match the same entry.
- R7: A pair sum is written into the pair store only on a pair miss with `reuse_en`=1 and `req_keep`=1. With `req_keep`=0 a later identical request still misses.
- R8: With `reuse_en` low the pair store is neither read nor written: `rsp_pair_hit` is 0, and a sum formed then is not found after reuse is turned on.
- R9: The feature store holds FEAT_WAYS vectors. A fill into a full store evicts the entry least recently hit or filled.
- R10: The pair store holds PAIR_WAYS sums with the same least-recently-used eviction.
- R11: While `rsp_valid` is high and `rsp_ready` is low, the response holds steady and `req_ready` stays low. `mem_req_valid` and `mem_req_node` hold until accepted.
- R12: After reset both stores are empty, `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reuse_en | input | 1 | Enables pair-store lookup and fill |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_pair | input | 1 | 1: two-node request, 0: single node |
| req_node_a | input | NODE_W | First node ID |
| req_node_b | input | NODE_W | Second node ID (pair only) |
| req_keep | input | 1 | Store the fresh pair sum on a pair miss |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | LANES*ELEM_W | Feature vector or pair sum |
| rsp_pair_hit | output | 1 | Response came from the pair store |
| mem_req_valid | output | 1 | Memory fetch request valid |
| mem_req_ready | input | 1 | Memory accepts the fetch |
| mem_req_node | output | NODE_W | Node ID to fetch |
| mem_rsp_valid | input | 1 | Fetched vector valid |
| mem_rsp_ready | output | 1 | Block is waiting for fetched data |
| mem_rsp_data | input | LANES*ELEM_W | Fetched feature vector |

## Verification
A wrong tag, valid bit or age in either store shows up at the ports on the next request that touches that node or pair. The symptoms are an extra or a missing memory request, a wrong `rsp_pair_hit`, or a response one cycle late instead of next-cycle. A corrupted accumulator or fill path shows up as a wrong `rsp_data` on the response that uses it. A wrong replacement choice appears only a few requests later, when the entry that should have survived is asked for again. The bench therefore replays ordered access patterns that separate true recency from insertion order.

// File: rtl/agg_cache_pkg.sv
`timescale 1ns/1ps
package agg_cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_WAIT  = 2'd2,
    ST_RESP  = 2'd3
  } agg_state_e;
endpackage

// File: rtl/agg_lru_store.sv
`timescale 1ns/1ps
// Fully associative tag/data store with age-based LRU (age 0 = most recent).
module agg_lru_store #(
  parameter int TAG_W  = 8,
  parameter int DATA_W = 64,
  parameter int WAYS   = 4,
  parameter int PORTS  = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [PORTS-1:0][TAG_W-1:0]    lk_tag,
  output logic [PORTS-1:0]               lk_hit,
  output logic [PORTS-1:0][DATA_W-1:0]   lk_data,
  input  logic [PORTS-1:0]               lk_touch,
  input  logic                           fill_en,
  input  logic [TAG_W-1:0]               fill_tag,
  input  logic [DATA_W-1:0]              fill_data
);
  localparam int AGE_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(WAYS - 1);

  logic [WAYS-1:0]   vld_q;
  logic [TAG_W-1:0]  tag_q [WAYS];
  logic [DATA_W-1:0] dat_q [WAYS];
  logic [AGE_W-1:0]  age_q [WAYS];
  logic [AGE_W-1:0]  age_d [WAYS];
  logic [AGE_W-1:0]  hit_way [PORTS];
  logic [AGE_W-1:0]  vic_way;
  logic              vic_found;
  logic [AGE_W-1:0]  ref_age;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    logic              hit_l;
    logic [AGE_W-1:0]  way_l;
    logic [DATA_W-1:0] dat_l;
    always_comb begin
      hit_l = 1'b0;
      way_l = '0;
      dat_l = '0;
      for (int i = 0; i < WAYS; i++) begin
        if (vld_q[i] && (tag_q[i] == lk_tag[p]) && !hit_l) begin
          hit_l = 1'b1;
          way_l = AGE_W'(i);
          dat_l = dat_q[i];
        end
      end
    end
    assign lk_hit[p]  = hit_l;
    assign lk_data[p] = dat_l;
    assign hit_way[p] = way_l;
  end

  // Victim: lowest empty way, otherwise the oldest way.
  always_comb begin
    vic_way   = '0;
    vic_found = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (!vld_q[i] && !vic_found) begin
        vic_way   = AGE_W'(i);
        vic_found = 1'b1;
      end
    end
    if (!vic_found) begin
      for (int i = 0; i < WAYS; i++) begin
        if (age_q[i] == AGE_OLDEST) vic_way = AGE_W'(i);
      end
    end
  end

  // Touches apply in port order, then a fill touches the victim.
  always_comb begin
    ref_age = '0;
    for (int i = 0; i < WAYS; i++) age_d[i] = age_q[i];
    for (int p = 0; p < PORTS; p++) begin
      if (lk_touch[p] && lk_hit[p]) begin
        ref_age = age_d[hit_way[p]];
        for (int i = 0; i < WAYS; i++) begin
          if (age_d[i] < ref_age) age_d[i] = age_d[i] + 1'b1;
        end
        age_d[hit_way[p]] = '0;
      end
    end
    if (fill_en) begin
      ref_age = age_d[vic_way];
      for (int i = 0; i < WAYS; i++) begin
        if (age_d[i] < ref_age) age_d[i] = age_d[i] + 1'b1;
      end
      age_d[vic_way] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < WAYS; i++) age_q[i] <= AGE_W'(i);
    end else begin
      for (int i = 0; i < WAYS; i++) age_q[i] <= age_d[i];
      if (fill_en) vld_q[vic_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[vic_way] <= fill_tag;
      dat_q[vic_way] <= fill_data;
    end
  end
endmodule

// File: rtl/agg_vec_add.sv
`timescale 1ns/1ps
// Lane-wise three-input adder, each lane wraps modulo 2^ELEM_W.
module agg_vec_add #(
  parameter int LANES  = 4,
  parameter int ELEM_W = 16
) (
  input  logic [LANES*ELEM_W-1:0] in0,
  input  logic [LANES*ELEM_W-1:0] in1,
  input  logic [LANES*ELEM_W-1:0] in2,
  output logic [LANES*ELEM_W-1:0] sum
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign sum[l*ELEM_W +: ELEM_W] = in0[l*ELEM_W +: ELEM_W]
                                   + in1[l*ELEM_W +: ELEM_W]
                                   + in2[l*ELEM_W +: ELEM_W];
  end
endmodule

// File: rtl/agg_reuse_cache.sv
`timescale 1ns/1ps
module agg_reuse_cache
  import agg_cache_pkg::*;
#(
  parameter int NODE_W    = 8,
  parameter int ELEM_W    = 16,
  parameter int LANES     = 4,
  parameter int FEAT_WAYS = 4,
  parameter int PAIR_WAYS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reuse_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_pair,
  input  logic [NODE_W-1:0]       req_node_a,
  input  logic [NODE_W-1:0]       req_node_b,
  input  logic                    req_keep,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [LANES*ELEM_W-1:0] rsp_data,
  output logic                    rsp_pair_hit,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [NODE_W-1:0]       mem_req_node,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [LANES*ELEM_W-1:0] mem_rsp_data
);
  localparam int VEC_W  = LANES * ELEM_W;
  localparam int PKEY_W = 2 * NODE_W;

  agg_state_e         state_q;
  logic [NODE_W-1:0]  a_q, b_q, fnode_q;
  logic [PKEY_W-1:0]  pkey_q;
  logic               keep_q, cur_a_q, miss_b_q, phit_q;
  logic [VEC_W-1:0]   acc_q;

  // Lookup and control signals
  logic               accept, use_phit, miss_a0, miss_b0, dup, more, mem_done;
  logic [PKEY_W-1:0]  pkey;
  logic [1:0][NODE_W-1:0] f_tag;
  logic [1:0]         f_hit, f_touch;
  logic [1:0][VEC_W-1:0] f_data;
  logic [0:0][PKEY_W-1:0] p_tag;
  logic [0:0]         p_hit, p_touch;
  logic [0:0][VEC_W-1:0] p_data;
  logic               p_fill_en, fill_idle, fill_wait;
  logic [PKEY_W-1:0]  p_fill_tag;
  logic [VEC_W-1:0]   p_fill_data;
  logic [VEC_W-1:0]   init_a, init_b, init_sum, dup_add, wait_sum;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign pkey      = (req_node_a < req_node_b) ? {req_node_a, req_node_b}
                                               : {req_node_b, req_node_a};

  assign f_tag[0]  = req_node_a;
  assign f_tag[1]  = req_node_b;
  assign p_tag[0]  = pkey;

  assign use_phit   = req_pair && reuse_en && p_hit[0];
  assign p_touch[0] = accept && use_phit;
  assign f_touch[0] = accept && !use_phit && f_hit[0];
  assign f_touch[1] = accept && !use_phit && req_pair && f_hit[1];
  assign miss_a0    = !f_hit[0];
  assign miss_b0    = req_pair && !f_hit[1];

  assign init_a   = f_hit[0] ? f_data[0] : '0;
  assign init_b   = (req_pair && f_hit[1]) ? f_data[1] : '0;
  assign mem_done = (state_q == ST_WAIT) && mem_rsp_valid;
  assign dup      = cur_a_q && miss_b_q && (b_q == a_q);
  assign more     = cur_a_q && miss_b_q && !dup;
  assign dup_add  = dup ? mem_rsp_data : '0;

  assign fill_idle   = accept && !use_phit && !miss_a0 && !miss_b0 &&
                       req_pair && reuse_en && req_keep;
  assign fill_wait   = mem_done && !more && keep_q;
  assign p_fill_en   = fill_idle || fill_wait;
  assign p_fill_tag  = fill_idle ? pkey : pkey_q;
  assign p_fill_data = fill_idle ? init_sum : wait_sum;

  agg_lru_store #(.TAG_W(NODE_W), .DATA_W(VEC_W), .WAYS(FEAT_WAYS), .PORTS(2)) u_feat (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(f_tag), .lk_hit(f_hit), .lk_data(f_data), .lk_touch(f_touch),
    .fill_en(mem_done), .fill_tag(fnode_q), .fill_data(mem_rsp_data)
  );

  agg_lru_store #(.TAG_W(PKEY_W), .DATA_W(VEC_W), .WAYS(PAIR_WAYS), .PORTS(1)) u_pair (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(p_tag), .lk_hit(p_hit), .lk_data(p_data), .lk_touch(p_touch),
    .fill_en(p_fill_en), .fill_tag(p_fill_tag), .fill_data(p_fill_data)
  );

  agg_vec_add #(.LANES(LANES), .ELEM_W(ELEM_W)) u_add_init (
    .in0(init_a), .in1(init_b), .in2('0), .sum(init_sum)
  );

  agg_vec_add #(.LANES(LANES), .ELEM_W(ELEM_W)) u_add_wait (
    .in0(acc_q), .in1(mem_rsp_data), .in2(dup_add), .sum(wait_sum)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      a_q      <= '0;
      b_q      <= '0;
      fnode_q  <= '0;
      pkey_q   <= '0;
      keep_q   <= 1'b0;
      cur_a_q  <= 1'b0;
      miss_b_q <= 1'b0;
      phit_q   <= 1'b0;
      acc_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (accept) begin
          a_q    <= req_node_a;
          b_q    <= req_node_b;
          pkey_q <= pkey;
          keep_q <= req_pair && reuse_en && req_keep;
          if (use_phit) begin
            acc_q   <= p_data[0];
            phit_q  <= 1'b1;
            state_q <= ST_RESP;
          end else begin
            acc_q    <= init_sum;
            phit_q   <= 1'b0;
            miss_b_q <= miss_b0;
            if (miss_a0) begin
              fnode_q <= req_node_a;
              cur_a_q <= 1'b1;
              state_q <= ST_FETCH;
            end else if (miss_b0) begin
              fnode_q <= req_node_b;
              cur_a_q <= 1'b0;
              state_q <= ST_FETCH;
            end else begin
              state_q <= ST_RESP;
            end
          end
        end
        ST_FETCH: if (mem_req_ready) state_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          acc_q <= wait_sum;
          if (more) begin
            fnode_q <= b_q;
            cur_a_q <= 1'b0;
            state_q <= ST_FETCH;
          end else begin
            state_q <= ST_RESP;
          end
        end
        ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_data      = acc_q;
  assign rsp_pair_hit  = phit_q;
  assign mem_req_valid = (state_q == ST_FETCH);
  assign mem_req_node  = fnode_q;
  assign mem_rsp_ready = (state_q == ST_WAIT);
endmodule

// File: rtl/agg_reuse_cache_chk.sv
`timescale 1ns/1ps
module agg_reuse_cache_chk #(
  parameter int NODE_W    = 8,
  parameter int ELEM_W    = 16,
  parameter int LANES     = 4,
  parameter int FEAT_WAYS = 4,
  parameter int PAIR_WAYS = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    reuse_en,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    req_pair,
  input logic [NODE_W-1:0]       req_node_a,
  input logic [NODE_W-1:0]       req_node_b,
  input logic                    req_keep,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [LANES*ELEM_W-1:0] rsp_data,
  input logic                    rsp_pair_hit,
  input logic                    mem_req_valid,
  input logic                    mem_req_ready,
  input logic [NODE_W-1:0]       mem_req_node,
  input logic                    mem_rsp_valid,
  input logic                    mem_rsp_ready,
  input logic [LANES*ELEM_W-1:0] mem_rsp_data
);
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_pair_hit)); // R11

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R11

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_node)); // R2

  AST_MEM_RSP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid && !rsp_valid && !req_ready); // R2

  AST_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid || mem_req_valid); // R1

  AST_REUSE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !reuse_en |=> !rsp_pair_hit); // R8

  AST_SINGLE_NO_PHIT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_pair |=> !rsp_pair_hit); // R4
endmodule

bind agg_reuse_cache agg_reuse_cache_chk #(
  .NODE_W(NODE_W), .ELEM_W(ELEM_W), .LANES(LANES),
  .FEAT_WAYS(FEAT_WAYS), .PAIR_WAYS(PAIR_WAYS)
) u_chk (.*);

// File: tb/sim_agg_reuse_cache.sv
`timescale 1ns/1ps
module sim_agg_reuse_cache;
  localparam int NODE_W = 8;
  localparam int ELEM_W = 16;
  localparam int LANES  = 4;
  localparam int VEC_W  = LANES * ELEM_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reuse_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic req_pair = 1'b0;
  logic [NODE_W-1:0] req_node_a = '0;
  logic [NODE_W-1:0] req_node_b = '0;
  logic req_keep = 1'b0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [VEC_W-1:0] rsp_data;
  logic rsp_pair_hit;
  logic mem_req_valid;
  logic mem_req_ready = 1'b1;
  logic [NODE_W-1:0] mem_req_node;
  logic mem_rsp_valid = 1'b0;
  logic mem_rsp_ready;
  logic [VEC_W-1:0] mem_rsp_data = '0;

  always #2.5 clk = ~clk;

  agg_reuse_cache u0 (
    .clk(clk), .rst_n(rst_n), .reuse_en(reuse_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_pair(req_pair),
    .req_node_a(req_node_a), .req_node_b(req_node_b), .req_keep(req_keep),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_pair_hit(rsp_pair_hit),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_node(mem_req_node), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data)
  );

  int total = 0;
  int bad = 0;
  int fetches = 0;
  int stall_n = 0;
  bit finished = 1'b0;
  logic [VEC_W-1:0] exp_data_q[$];
  bit exp_phit_q[$];
  string exp_tag_q[$];

  function automatic logic [VEC_W-1:0] feat(input logic [NODE_W-1:0] n);
    logic [VEC_W-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*ELEM_W +: ELEM_W] = {n, 8'(k*17 + 3)};
    return v;
  endfunction

  function automatic logic [VEC_W-1:0] vadd(input logic [VEC_W-1:0] x, input logic [VEC_W-1:0] y);
    logic [VEC_W-1:0] v;
    for (int k = 0; k < LANES; k++) v[k*ELEM_W +: ELEM_W] = x[k*ELEM_W +: ELEM_W] + y[k*ELEM_W +: ELEM_W];
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [VEC_W-1:0] act, input logic [VEC_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Memory model: data = feat(node), latency depends on node.
  initial begin
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      #1;
      if (rst_n && mem_req_valid) begin
        logic [NODE_W-1:0] nd;
        nd = mem_req_node;
        fetches++;
        repeat (int'(nd[1:0]) + 1) @(negedge clk);
        mem_rsp_data  = feat(nd);
        mem_rsp_valid = 1'b1;
      end
    end
  end

  // Monitor: optional back-pressure, then pop and compare.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rsp_valid) begin
        if (stall_n > 0) begin
          logic [VEC_W-1:0] held;
          held = rsp_data;
          rsp_ready = 1'b0;
          repeat (stall_n) begin
            @(negedge clk);
            #1;
            chk(rsp_valid && rsp_data == held && !req_ready, "R11", "held response",
                rsp_data, held);
          end
          stall_n = 0;
          rsp_ready = 1'b1;
        end
        if (exp_data_q.size() == 0) begin
          chk(1'b0, "R11", "unexpected response", rsp_data, '0);
        end else begin
          logic [VEC_W-1:0] ed;
          bit ep;
          string et;
          ed = exp_data_q.pop_front();
          ep = exp_phit_q.pop_front();
          et = exp_tag_q.pop_front();
          chk(rsp_data == ed, et, "rsp_data", rsp_data, ed);
          chk(rsp_pair_hit == ep, et, "rsp_pair_hit", VEC_W'(rsp_pair_hit), VEC_W'(ep));
        end
      end
    end
  end

  task automatic issue(input bit pair, input logic [NODE_W-1:0] a, input logic [NODE_W-1:0] b,
                       input bit reuse, input bit keep, input bit exp_phit,
                       input int exp_fetch, input int stall, input string tag);
    int f0;
    logic [VEC_W-1:0] ed;
    ed = pair ? vadd(feat(a), feat(b)) : feat(a);
    @(negedge clk);
    exp_data_q.push_back(ed);
    exp_phit_q.push_back(exp_phit);
    exp_tag_q.push_back(tag);
    stall_n    = stall;
    f0         = fetches;
    req_pair   = pair;
    req_node_a = a;
    req_node_b = b;
    reuse_en   = reuse;
    req_keep   = keep;
    req_valid  = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (exp_fetch == 0)
      chk(rsp_valid, tag, "response one cycle after accept", VEC_W'(rsp_valid), 1);
    while (exp_data_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(fetches - f0 == exp_fetch, tag, "memory fetch count",
        VEC_W'(fetches - f0), VEC_W'(exp_fetch));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R12", "req_ready after reset", VEC_W'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R12", "rsp_valid after reset", VEC_W'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R12", "mem_req_valid after reset", VEC_W'(mem_req_valid), 0);

    issue(0, 8'd5, 8'd0, 1, 0, 0, 1, 0, "R2");   // empty store: miss + fetch (also R12)
    issue(0, 8'd5, 8'd0, 1, 0, 0, 0, 0, "R1");   // single hit
    issue(1, 8'd5, 8'd9, 1, 1, 0, 1, 0, "R5");   // pair miss, node 9 fetched, sum stored
    issue(1, 8'd9, 8'd5, 1, 0, 1, 0, 0, "R6");   // swapped order hits (R4)
    issue(1, 8'd5, 8'd9, 0, 1, 0, 0, 0, "R8");   // reuse off: no pair hit
    issue(1, 8'd7, 8'd8, 0, 1, 0, 2, 3, "R3");   // two fetches, stalled response (R11)
    issue(1, 8'd8, 8'd7, 1, 0, 0, 0, 0, "R8");   // not stored while reuse was off
    issue(1, 8'd7, 8'd8, 1, 0, 0, 0, 0, "R7");   // keep=0 never stores
    issue(0, 8'd5, 8'd0, 1, 0, 0, 0, 0, "R9");   // touch 5: order 9,7,8,5
    issue(0, 8'd12, 8'd0, 1, 0, 0, 1, 0, "R9");  // evicts 9
    issue(0, 8'd9, 8'd0, 1, 0, 0, 1, 0, "R9");   // 9 gone, evicts 7
    issue(0, 8'd5, 8'd0, 1, 0, 0, 0, 2, "R9");   // 5 survives (R11 stall)
    issue(1, 8'd3, 8'd3, 1, 1, 0, 1, 0, "R5");   // same node twice: one fetch, doubled
    issue(1, 8'd3, 8'd3, 1, 0, 1, 0, 0, "R4");   // now a pair hit
    issue(1, 8'd5, 8'd12, 1, 1, 0, 0, 0, "R7");  // stored from feature hits
    issue(1, 8'd12, 8'd9, 1, 1, 0, 0, 0, "R7");
    issue(1, 8'd5, 8'd9, 1, 0, 1, 0, 0, "R10");  // touch (5,9)
    issue(1, 8'd3, 8'd5, 1, 1, 0, 0, 0, "R10");  // insert evicts (3,3)
    issue(1, 8'd3, 8'd3, 1, 0, 0, 0, 0, "R10");  // (3,3) gone
    issue(1, 8'd9, 8'd5, 1, 0, 1, 0, 0, "R10");  // (5,9) kept
    issue(1, 8'd12, 8'd5, 1, 0, 1, 0, 0, "R6");

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R11 actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule